// File: doc/BRIEF.md
# Multi-Mode Block DMA Engine

This engine moves 16-bit words between a 22-bit byte-addressed memory and a few targets. A transfer is made of blocks, and each block is made of words. Software loads the source and destination addresses one byte at a time, together with a word count per block and a block count. It then pulses `start` with a mode code and three option flags. The engine walks both addresses two bytes per word. At the end of each block, a side whose align flag is set jumps to its block start plus a 256-byte or 512-byte stride. A side whose align flag is clear carries on from where the block ended.

Six modes share one sequencer:
- memory copy;
- writing an SPI word stream into memory;
- filling memory with a single word;
- a transparent merge, where nonzero source nibbles or bytes overwrite the destination;
- copying memory to a colour-RAM write port;
- copying memory to a sprite-file write port.

The address registers are live. After a transfer they hold the addresses where the next transfer would begin, so a follow-up transfer needs no reload.

Memory, SPI and the colour/sprite write port are valid/ready streams. A transfer is accepted on the clock edge where both valid and ready are high. While ready is low, the engine holds its request (address, direction and write data) unchanged. On the SPI input, the engine raises `spi_ready` only while it waits for a word. The source must hold `spi_data` steady while `spi_valid` is high. Memory read data is taken from `mem_rdata` on the accepting edge. `ready` and `done` are plain status pins.

Top module: `blk_dma`

## Requirements
- R1: Configuration writes while idle use `cfg_sel`:
  - 0, 1 and 2 load the source address; 3, 4 and 5 load the destination address. In each group, the first code loads the low byte with bit 0 forced to 0, the second loads bits 13:8 from data bits 5:0, and the third loads bits 21:14.
  - 6 loads the word count minus one.
  - 7 and 8 load the low and high bytes of the block count minus one.
  - Every address on `mem_addr` is even.
- R2: A transfer moves (blocks+1) × (words+1) words, in address order within a block.
- R3: Within a block, each active address rises by 2 per word, modulo 2^22 (0x3FFFFE is followed by 0x000000).
- R4: At the end of each block, an aligned side restarts at its block start plus the stride: 512 bytes when `start_wide`=1, else 256. An unaligned side continues from the address after the block's last word.
- R5: Mode 4'b0001 reads each source word and then writes it to the destination.
- R6: Mode 4'b0010 takes one SPI word per destination word and writes it. The source address is not used and does not move.
- R7: Mode 4'b0100 reads the source address once, then writes that word to every destination word. The source address does not move.
- R8: Mode 4'b0101 reads the destination word, then the source word, then writes the merge:
  - with `start_wide`=1, each nonzero source byte replaces the destination byte;
  - with `start_wide`=0, each nonzero source nibble replaces the destination nibble.
- R9: Modes 4'b1100 and 4'b1101 read each source word and send it on the aux port at the destination address. `aux_sprite` is 0 for colour RAM and 1 for the sprite file.
- R10: Handshake and completion timing:
  - `ready` falls in the cycle after `start` is sampled high.
  - `done` is a one-cycle pulse, high together with `ready`, two cycles after the final write is accepted.
  - Any other mode code makes no access, and `done` is high two cycles after start.
- R11: A stalled memory or aux request keeps valid, address, direction and data unchanged until it is accepted.
- R12: `start` and configuration writes are ignored while a transfer runs.
- R13: After a transfer, the address registers hold the next-start addresses, and a new transfer without a reload continues from them.
- R14: Reset clears the address, word-count and block-count registers, so an unconfigured transfer moves one word from address 0 to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | 8 | Configuration byte |
| start | input | 1 | Start a transfer |
| start_mode | input | 4 | Mode code |
| start_src_align | input | 1 | Source align at block end |
| start_dst_align | input | 1 | Destination align at block end |
| start_wide | input | 1 | 512-byte stride and byte-wise merge |
| ready | output | 1 | Idle and able to start |
| done | output | 1 | Completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 22 | Memory byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, taken on acceptance |
| spi_valid | input | 1 | SPI word valid |
| spi_ready | output | 1 | Engine waits for an SPI word |
| spi_data | input | 16 | SPI word |
| aux_valid | output | 1 | Colour/sprite write valid |
| aux_ready | input | 1 | Colour/sprite write accepted |
| aux_sprite | output | 1 | 0 colour RAM, 1 sprite file |
| aux_addr | output | 22 | Colour/sprite address |
| aux_data | output | 16 | Colour/sprite word |

## Verification
Each request appears in the cycle after the previous acceptance edge, or in the cycle after `start` for the first one. It takes effect on the first edge where the matching ready or valid is high. The bench randomises those ready and valid inputs at each falling edge and compares any pending acceptance against the next entry in its expected access list before the edge that completes it.

`ready` is checked low one falling edge after `start` was driven. `done` is expected two edges after the final acceptance, checked one cycle later for its drop, and for an unknown mode it is expected exactly two falling edges after start.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

  localparam logic [3:0] MODE_COPY  = 4'b0001;
  localparam logic [3:0] MODE_SPI   = 4'b0010;
  localparam logic [3:0] MODE_FILL  = 4'b0100;
  localparam logic [3:0] MODE_BLIT  = 4'b0101;
  localparam logic [3:0] MODE_CRAM  = 4'b1100;
  localparam logic [3:0] MODE_SFILE = 4'b1101;

  localparam logic [3:0] SEL_SRC_LO = 4'd0;
  localparam logic [3:0] SEL_SRC_HI = 4'd1;
  localparam logic [3:0] SEL_SRC_EX = 4'd2;
  localparam logic [3:0] SEL_DST_LO = 4'd3;
  localparam logic [3:0] SEL_DST_HI = 4'd4;
  localparam logic [3:0] SEL_DST_EX = 4'd5;
  localparam logic [3:0] SEL_LEN    = 4'd6;
  localparam logic [3:0] SEL_NUM_LO = 4'd7;
  localparam logic [3:0] SEL_NUM_HI = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SRC, ST_RD_DST, ST_SPI, ST_WRITE, ST_AUX, ST_END
  } dma_state_e;

  // modes whose source pointer advances word by word
  function automatic logic src_walks(input logic [3:0] m);
    return (m == MODE_COPY) || (m == MODE_BLIT) || (m == MODE_CRAM) || (m == MODE_SFILE);
  endfunction

  // state that begins the handling of each word
  function automatic dma_state_e word_entry(input logic [3:0] m);
    case (m)
      MODE_COPY, MODE_CRAM, MODE_SFILE: return ST_RD_SRC;
      MODE_BLIT:                        return ST_RD_DST;
      MODE_SPI:                         return ST_SPI;
      MODE_FILL:                        return ST_WRITE;
      default:                          return ST_END;
    endcase
  endfunction

endpackage

// File: rtl/blk_dma_merge.sv
module blk_dma_merge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic          byte_mode,
  output logic [DW-1:0] merged
);
  localparam int NIBS = DW / 4;
  localparam int BYTES = DW / 8;

  logic [NIBS-1:0]  nib_nz;
  logic [BYTES-1:0] byte_nz;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_nz[b] = |src[8*b +: 8];
  end

  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    assign nib_nz[n] = |src[4*n +: 4];
    assign merged[4*n +: 4] = (byte_mode ? byte_nz[n/2] : nib_nz[n]) ? src[4*n +: 4] : dst[4*n +: 4];
  end
endmodule

// File: rtl/blk_dma_regs.sv
module blk_dma_regs import blk_dma_pkg::*; #(
  parameter int AW    = 22,
  parameter int LEN_W = 8,
  parameter int NUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_sel,
  input  logic [7:0]       cfg_data,
  input  logic             word_step,
  input  logic             block_end,
  input  logic             src_walk,
  input  logic             src_align,
  input  logic             dst_align,
  input  logic             wide,
  output logic [AW-1:0]    s_ptr,
  output logic [AW-1:0]    d_ptr,
  output logic [LEN_W-1:0] blk_len,
  output logic [NUM_W-1:0] blk_num
);
  localparam int EXT_W = AW - 14;

  logic [AW-1:0] s_base, d_base, stride, s_next, d_next;

  assign stride = wide ? AW'(512) : AW'(256);
  assign s_next = s_ptr + AW'(2);
  assign d_next = d_ptr + AW'(2);

  function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] cur, input logic [1:0] part,
                                             input logic [7:0] d);
    case (part)
      2'd0:    return {cur[AW-1:8], d[7:1], 1'b0};
      2'd1:    return {cur[AW-1:14], d[5:0], cur[7:0]};
      default: return {d[EXT_W-1:0], cur[13:0]};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_base  <= '0;
      s_ptr   <= '0;
      d_base  <= '0;
      d_ptr   <= '0;
      blk_len <= '0;
      blk_num <= '0;
    end else if (idle && cfg_we) begin
      case (cfg_sel)
        SEL_SRC_LO, SEL_SRC_HI, SEL_SRC_EX: begin
          s_base <= put_byte(s_base, cfg_sel[1:0], cfg_data);
          s_ptr  <= put_byte(s_base, cfg_sel[1:0], cfg_data);
        end
        SEL_DST_LO, SEL_DST_HI, SEL_DST_EX: begin
          d_base <= put_byte(d_base, 2'(cfg_sel - SEL_DST_LO), cfg_data);
          d_ptr  <= put_byte(d_base, 2'(cfg_sel - SEL_DST_LO), cfg_data);
        end
        SEL_LEN:    blk_len <= cfg_data[LEN_W-1:0];
        SEL_NUM_LO: blk_num[7:0] <= cfg_data;
        SEL_NUM_HI: blk_num[NUM_W-1:8] <= cfg_data[NUM_W-9:0];
        default: ;
      endcase
    end else if (word_step) begin
      if (block_end) begin
        if (src_walk) begin
          s_base <= src_align ? s_base + stride : s_next;
          s_ptr  <= src_align ? s_base + stride : s_next;
        end
        d_base <= dst_align ? d_base + stride : d_next;
        d_ptr  <= dst_align ? d_base + stride : d_next;
      end else begin
        if (src_walk) s_ptr <= s_next;
        d_ptr <= d_next;
      end
    end
  end
endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl import blk_dma_pkg::*; #(
  parameter int AW    = 22,
  parameter int DW    = 16,
  parameter int LEN_W = 8,
  parameter int NUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       start_mode,
  input  logic             start_src_align,
  input  logic             start_dst_align,
  input  logic             start_wide,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [NUM_W-1:0] blk_num,
  input  logic [AW-1:0]    s_ptr,
  input  logic [AW-1:0]    d_ptr,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             spi_valid,
  input  logic [DW-1:0]    spi_data,
  input  logic             aux_ready,
  input  logic [DW-1:0]    merged,
  output logic             idle,
  output logic             done,
  output logic             mem_valid,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             spi_ready,
  output logic             aux_valid,
  output logic             aux_sprite,
  output logic             word_step,
  output logic             block_end,
  output logic             src_walk,
  output logic             src_align,
  output logic             dst_align,
  output logic             wide,
  output logic [DW-1:0]    src_word,
  output logic [DW-1:0]    dst_word
);
  dma_state_e       state;
  logic [3:0]       mode_q;
  logic [LEN_W-1:0] wcnt;
  logic [NUM_W-1:0] bcnt;
  logic             last_word, last_all;

  assign idle      = (state == ST_IDLE);
  assign mem_valid = (state == ST_RD_SRC) || (state == ST_RD_DST) || (state == ST_WRITE);
  assign mem_write = (state == ST_WRITE);
  assign mem_addr  = (state == ST_RD_SRC) ? s_ptr : d_ptr;
  assign mem_wdata = (mode_q == MODE_BLIT) ? merged : src_word;
  assign spi_ready = (state == ST_SPI);
  assign aux_valid = (state == ST_AUX);
  assign aux_sprite = mode_q[0];
  assign src_walk  = src_walks(mode_q);
  assign word_step = ((state == ST_WRITE) && mem_ready) || ((state == ST_AUX) && aux_ready);
  assign last_word = (wcnt == blk_len);
  assign last_all  = last_word && (bcnt == blk_num);
  assign block_end = word_step && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_q    <= '0;
      src_align <= 1'b0;
      dst_align <= 1'b0;
      wide      <= 1'b0;
      wcnt      <= '0;
      bcnt      <= '0;
      src_word  <= '0;
      dst_word  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          mode_q    <= start_mode;
          src_align <= start_src_align;
          dst_align <= start_dst_align;
          wide      <= start_wide;
          wcnt      <= '0;
          bcnt      <= '0;
          state     <= (start_mode == MODE_FILL) ? ST_RD_SRC : word_entry(start_mode);
        end
        ST_RD_DST: if (mem_ready) begin
          dst_word <= mem_rdata;
          state    <= ST_RD_SRC;
        end
        ST_RD_SRC: if (mem_ready) begin
          src_word <= mem_rdata;
          state    <= ((mode_q == MODE_CRAM) || (mode_q == MODE_SFILE)) ? ST_AUX : ST_WRITE;
        end
        ST_SPI: if (spi_valid) begin
          src_word <= spi_data;
          state    <= ST_WRITE;
        end
        ST_WRITE, ST_AUX: if (word_step) begin
          if (last_word) begin
            wcnt <= '0;
            bcnt <= bcnt + NUM_W'(1);
          end else begin
            wcnt <= wcnt + LEN_W'(1);
          end
          state <= last_all ? ST_END : word_entry(mode_q);
        end
        ST_END: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_dma.sv
module blk_dma import blk_dma_pkg::*; #(
  parameter int AW    = 22,
  parameter int DW    = 16,
  parameter int LEN_W = 8,
  parameter int NUM_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [7:0]    cfg_data,
  input  logic          start,
  input  logic [3:0]    start_mode,
  input  logic          start_src_align,
  input  logic          start_dst_align,
  input  logic          start_wide,
  output logic          ready,
  output logic          done,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          spi_valid,
  output logic          spi_ready,
  input  logic [DW-1:0] spi_data,
  output logic          aux_valid,
  input  logic          aux_ready,
  output logic          aux_sprite,
  output logic [AW-1:0] aux_addr,
  output logic [DW-1:0] aux_data
);
  logic [AW-1:0]    s_ptr, d_ptr;
  logic [LEN_W-1:0] blk_len;
  logic [NUM_W-1:0] blk_num;
  logic             word_step, block_end, src_walk, src_align, dst_align, wide;
  logic [DW-1:0]    src_word, dst_word, merged;

  assign aux_addr = d_ptr;
  assign aux_data = src_word;

  blk_dma_regs #(.AW(AW), .LEN_W(LEN_W), .NUM_W(NUM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .idle(ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .word_step(word_step), .block_end(block_end),
    .src_walk(src_walk), .src_align(src_align), .dst_align(dst_align), .wide(wide),
    .s_ptr(s_ptr), .d_ptr(d_ptr), .blk_len(blk_len), .blk_num(blk_num)
  );

  blk_dma_merge #(.DW(DW)) u_merge (
    .src(src_word), .dst(dst_word), .byte_mode(wide), .merged(merged)
  );

  blk_dma_ctrl #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .NUM_W(NUM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
    .start_src_align(start_src_align), .start_dst_align(start_dst_align),
    .start_wide(start_wide), .blk_len(blk_len), .blk_num(blk_num),
    .s_ptr(s_ptr), .d_ptr(d_ptr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .spi_valid(spi_valid), .spi_data(spi_data), .aux_ready(aux_ready), .merged(merged),
    .idle(ready), .done(done), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .spi_ready(spi_ready),
    .aux_valid(aux_valid), .aux_sprite(aux_sprite), .word_step(word_step),
    .block_end(block_end), .src_walk(src_walk), .src_align(src_align),
    .dst_align(dst_align), .wide(wide), .src_word(src_word), .dst_word(dst_word)
  );
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ready,
  input logic          done,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          spi_ready,
  input logic          aux_valid,
  input logic          aux_ready,
  input logic [AW-1:0] aux_addr,
  input logic [DW-1:0] aux_data
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> ready);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (ready && start) |=> !ready);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !(mem_valid || aux_valid || spi_ready));
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));
  // R11
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_valid && !aux_ready) |=> (aux_valid && $stable(aux_addr) && $stable(aux_data)));
  // R1
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> !mem_addr[0]);
endmodule

bind blk_dma blk_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .done(done),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .spi_ready(spi_ready),
  .aux_valid(aux_valid), .aux_ready(aux_ready), .aux_addr(aux_addr), .aux_data(aux_data)
);

// File: tb/blk_dma_test.sv
`timescale 1ns/1ps
module blk_dma_test;
  localparam int MASK = 32'h3FFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, start = 0, start_src_align = 0, start_dst_align = 0, start_wide = 0;
  logic [3:0] cfg_sel = 0, start_mode = 0;
  logic [7:0] cfg_data = 0;
  logic ready, done, mem_valid, mem_write, spi_ready, aux_valid, aux_sprite;
  logic mem_ready = 0, spi_valid = 0, aux_ready = 0;
  logic [21:0] mem_addr, aux_addr;
  logic [15:0] mem_wdata, aux_data, mem_rdata = 0, spi_data = 0;

  always #2.5 clk = ~clk;

  blk_dma uut (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  logic [15:0] mem [int];
  logic [15:0] rmem [int];
  int q_kind[$], q_addr[$], q_sel[$];
  logic [15:0] q_data[$];
  string cur_tag = "R10";
  int m_s = 0, m_d = 0, m_len = 0, m_num = 0;
  logic [15:0] m_spi = 16'h7000, spi_cnt = 16'h7000;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] seed_word(input int a);
    return 16'((a >> 1) * 40503 + 16'h0F0F);
  endfunction
  function automatic logic [15:0] mem_get(input int a);
    return mem.exists(a) ? mem[a] : seed_word(a);
  endfunction
  function automatic logic [15:0] ref_get(input int a);
    return rmem.exists(a) ? rmem[a] : seed_word(a);
  endfunction

  function automatic logic [15:0] blend(input logic [15:0] s, input logic [15:0] d, input bit bytes);
    logic [15:0] r = d;
    if (bytes) begin
      for (int i = 0; i < 2; i++) if (s[8*i +: 8] != 0) r[8*i +: 8] = s[8*i +: 8];
    end else begin
      for (int i = 0; i < 4; i++) if (s[4*i +: 4] != 0) r[4*i +: 4] = s[4*i +: 4];
    end
    return r;
  endfunction

  task automatic push(input int k, input int a, input logic [15:0] d, input int s);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_sel.push_back(s);
  endtask

  // kinds: 0 memory read, 1 memory write, 2 spi word, 3 aux write
  task automatic handle(input int k, input int a, input logic [15:0] d, input int s);
    int ek, ea, es;
    logic [15:0] ed;
    if (q_kind.size() == 0) begin
      check(0, cur_tag, "unexpected access kind", k, -1);
      return;
    end
    ek = q_kind.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front(); es = q_sel.pop_front();
    check(k == ek, cur_tag, "access kind", k, ek);
    if (k != 2) check(a == ea, cur_tag, "access address", a, ea);
    if (k == 1 || k == 3) check(d == ed, cur_tag, "write data", d, ed);
    if (k == 3) check(s == es, "R9", "aux target", s, es);
  endtask

  // stimulus responder and comparison, once per falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem_ready = lf[0] | lf[3];
      spi_valid = lf[1] | lf[4];
      aux_ready = lf[2] | lf[5];
      mem_rdata = mem_get(int'(mem_addr));
      spi_data = spi_cnt;
      if (rst_n) begin
        if (mem_valid && mem_ready) begin
          handle(mem_write ? 1 : 0, int'(mem_addr), mem_wdata, 0);
          if (mem_write) mem[int'(mem_addr)] = mem_wdata;
        end
        if (spi_valid && spi_ready) begin
          handle(2, 0, spi_data, 0);
          spi_cnt++;
        end
        if (aux_valid && aux_ready) handle(3, int'(aux_addr), aux_data, int'(aux_sprite));
      end
      if (cyc > 150000) begin
        check(0, "R10", "watchdog expired", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
      end
    end
  end

  task automatic cfg(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: m_s = (m_s & 32'h3FFF00) | (d & 8'hFE);
      1: m_s = (m_s & 32'h3FC0FF) | ((d & 8'h3F) << 8);
      2: m_s = (m_s & 32'h003FFF) | (d << 14);
      3: m_d = (m_d & 32'h3FFF00) | (d & 8'hFE);
      4: m_d = (m_d & 32'h3FC0FF) | ((d & 8'h3F) << 8);
      5: m_d = (m_d & 32'h003FFF) | (d << 14);
      6: m_len = d;
      7: m_num = (m_num & 32'hFF00) | d;
      8: m_num = (m_num & 32'h00FF) | (d << 8);
      default: ;
    endcase
  endtask

  task automatic set_src(input int a);
    cfg(0, a[7:0]); cfg(1, a[15:8]); cfg(2, a[21:14]);
  endtask
  task automatic set_dst(input int a);
    cfg(3, a[7:0]); cfg(4, a[15:8]); cfg(5, a[21:14]);
  endtask
  task automatic set_size(input int len, input int num);
    cfg(6, len[7:0]); cfg(7, num[7:0]); cfg(8, num[15:8]);
  endtask
  task automatic preload(input int a, input logic [15:0] v);
    mem[a] = v; rmem[a] = v;
  endtask

  task automatic build(input logic [3:0] mode, input bit sal, input bit dal, input bit wide);
    int s = m_s, d = m_d, sp, dp, stride;
    bit walks;
    logic [15:0] v, dv, fw;
    stride = wide ? 512 : 256;
    walks = (mode == 1) || (mode == 5) || (mode == 12) || (mode == 13);
    if (!(walks || mode == 2 || mode == 4)) return;
    if (mode == 4) begin push(0, s, 0, 0); fw = ref_get(s); end
    for (int b = 0; b <= m_num; b++) begin
      sp = s; dp = d;
      for (int w = 0; w <= m_len; w++) begin
        case (mode)
          1: begin push(0, sp, 0, 0); v = ref_get(sp); push(1, dp, v, 0); rmem[dp] = v; end
          2: begin push(2, 0, m_spi, 0); v = m_spi; m_spi++; push(1, dp, v, 0); rmem[dp] = v; end
          4: begin push(1, dp, fw, 0); rmem[dp] = fw; end
          5: begin
            dv = ref_get(dp); push(0, dp, 0, 0); push(0, sp, 0, 0);
            v = blend(ref_get(sp), dv, wide); push(1, dp, v, 0); rmem[dp] = v;
          end
          default: begin push(0, sp, 0, 0); push(3, dp, ref_get(sp), mode == 13); end
        endcase
        if (walks) sp = (sp + 2) & MASK;
        dp = (dp + 2) & MASK;
      end
      if (walks) s = sal ? ((s + stride) & MASK) : sp;
      d = dal ? ((d + stride) & MASK) : dp;
    end
    m_s = s; m_d = d;
  endtask

  task automatic go(input string tag, input logic [3:0] mode, input bit sal, input bit dal,
                    input bit wide, input bit poke);
    int n = 0;
    cur_tag = tag;
    build(mode, sal, dal, wide);
    @(negedge clk);
    start = 1; start_mode = mode; start_src_align = sal; start_dst_align = dal; start_wide = wide;
    @(negedge clk);
    start = 0;
    check(ready == 0, "R10", "ready after start", ready, 0);
    if (poke) begin
      // R12: these must be ignored
      start = 1; cfg_we = 1; cfg_sel = 4'd3; cfg_data = 8'h80;
      @(negedge clk);
      start = 0; cfg_we = 0;
      n = 1;
    end
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (mode == 3) check(n == 2 - 1, "R10", "unknown mode done delay", n, 1);
    check(done == 1, "R10", "done seen", done, 1);
    check(ready == 1, "R10", "ready with done", ready, 1);
    check(q_kind.size() == 0, tag, "missing accesses", q_kind.size(), 0);
    @(negedge clk);
    check(done == 0, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready == 1, "R10", "reset ready", ready, 1);
    check(done == 0, "R10", "reset done", done, 0);
    check(mem_valid == 0 && aux_valid == 0 && spi_ready == 0, "R10", "reset quiet", mem_valid, 0);

    go("R14", 4'b0001, 0, 0, 0, 0);

    set_src(32'h8113); set_dst(32'h010200); set_size(3, 1);
    go("R1 R2 R5", 4'b0001, 0, 0, 0, 0);

    set_src(32'h000800); set_dst(32'h004000); set_size(1, 2);
    go("R4", 4'b0001, 1, 0, 0, 0);
    go("R4 R13", 4'b0001, 0, 1, 1, 0);
    go("R12 R13", 4'b0001, 1, 1, 0, 1);

    set_src(32'h3FFFFC); set_dst(32'h100000); set_size(3, 0);
    go("R3", 4'b0001, 0, 0, 0, 0);

    set_dst(32'h020000); set_size(2, 1);
    go("R6", 4'b0010, 0, 0, 0, 0);

    set_src(32'h030000); set_dst(32'h030100); set_size(4, 0);
    go("R7", 4'b0100, 0, 0, 0, 0);

    preload(32'h040000, 16'h0000); preload(32'h040002, 16'hF00A);
    preload(32'h040004, 16'h0A00); preload(32'h040006, 16'h1234);
    for (int i = 0; i < 4; i++) begin
      preload(32'h040100 + 2 * i, 16'h5555);
      preload(32'h040200 + 2 * i, 16'h5555);
    end
    set_src(32'h040000); set_dst(32'h040100); set_size(3, 0);
    go("R8", 4'b0101, 0, 0, 0, 0);
    set_src(32'h040000); set_dst(32'h040200);
    go("R8", 4'b0101, 0, 0, 1, 0);

    set_src(32'h050000); set_dst(32'h000040); set_size(2, 1);
    go("R9", 4'b1100, 0, 1, 0, 0);
    go("R9", 4'b1101, 1, 0, 1, 0);

    go("R10", 4'b0011, 0, 0, 0, 0);

    repeat (4) @(negedge clk);
    check(q_kind.size() == 0, "R10", "no stray accesses", q_kind.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule